// File: doc/BRIEF.md
# DMA Channel Control and Status Word Bank

This block keeps one 32-bit control and status word for each channel of a DMA controller. It also folds those words into a single interrupt summary for the whole controller. Software writes a word through a simple 32-bit write port that carries a channel index. A single write does two jobs. Some status bits are cleared by writing a one to them. The control bits are replaced with the written value.

The transfer engine reports what happens on each channel through single-cycle event vectors, with one bit per channel for each event. The events are start, end, stop, request-asserted, end-of-receive and bus error. An event sets the matching status bit. Readback takes a channel index and returns that channel's stored word combinationally. Bit 8 of the returned word reflects the channel's live request line.

The block derives five cause vectors, each with one bit per channel:
- stop, end-of-receive and request-asserted, each gated by its own enable bit;
- start and end, which need no enable.

Their OR forms the level interrupt output and the interrupt-register readback. The channel count is a parameter, 16 or 32.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every channel word reads 0x0000_0008, which is only the stop status bit (bit 3). All cause vectors and `irq` are 0.
- R2: On a write, the stored word keeps only its bits under mask 0x0000_071F. The written bits under mask 0xFC80_0000 are then ORed in. Written bits 22, 24 and 25 and all other bits are never stored.
- R3: Writing a 1 clears status bits 0 (bus error), 1 (start), 2 (end) and 9 (end-of-receive). A write never clears bit 4 (request-asserted) or bit 10 (compare status).
- R4: The stop status bit (bit 3) is cleared by a write that leaves bit 29 (stop interrupt enable) set in the word. It is also cleared by a write with bit 31 (run) set. After both of those rules, a write with bit 31 and bit 22 (mask-run) both 0 sets it.
- R5: Writing 1 to bit 24 clears compare status (bit 10), and writing 1 to bit 25 sets it. When both bits are written as 1, compare status ends up set.
- R6: Each event pulse sets its status bit in that channel's word. The bits are: bus error to bit 0, start to bit 1, end to bit 2, stop to bit 3, request-asserted to bit 4, end-of-receive to bit 9. An event wins over a write in the same cycle that would clear the same bit.
- R7: Three cause bits are gated by enables in the same word. The stop cause is bit 3 AND bit 29. The end-of-receive cause is bit 9 AND bit 28. The request-asserted cause is bit 4 AND bit 23.
- R8: The start and end causes equal bits 1 and 2 with no enable. The bus error bit drives no cause.
- R9: `irq_vec` is the OR of the five cause vectors, and `irq` is 1 exactly when `irq_vec` is nonzero.
- R10: Readback of a channel returns the stored word with bit 8 forced to 1 while that channel's `req_active` bit is 1. Bit 8 is never stored.
- R11: Words, cause vectors and `irq` change only on the clock edge after a write or an event. They do not change within the cycle in which the write or event is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one channel word |
| wr_chan | input | $clog2(NCH) | Channel index of the write |
| wr_data | input | 32 | Write data |
| ev_buserr | input | NCH | Bus error event pulses, one per channel |
| ev_start | input | NCH | Start event pulses |
| ev_end | input | NCH | End event pulses |
| ev_stop | input | NCH | Stop event pulses |
| ev_ras | input | NCH | Request-asserted event pulses |
| ev_eor | input | NCH | End-of-receive event pulses |
| req_active | input | NCH | Live request level of each channel |
| rd_chan | input | $clog2(NCH) | Channel index for readback |
| rd_data | output | 32 | Readback word of the selected channel |
| sum_stop | output | NCH | Gated stop cause per channel |
| sum_eor | output | NCH | Gated end-of-receive cause per channel |
| sum_ras | output | NCH | Gated request-asserted cause per channel |
| sum_start | output | NCH | Start cause per channel |
| sum_end | output | NCH | End cause per channel |
| irq_vec | output | NCH | OR of all five cause vectors |
| irq | output | 1 | Level interrupt, any cause present |

## Verification
A vector table walks one channel through a chain of writes. Each entry's result depends on the previous word, so it tells apart the keep mask, the control-bit overwrite, the three stop-bit rules in their order, and the set-wins compare case.

Directed sequences pulse each event on different channels with their enables on and off. This separates the gated causes from the ungated ones and shows that bus error raises no interrupt. Collisions of an event with a clearing write show which one takes priority. A live request line shows bit 8 in readback only, without being stored.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned WORD_W = 32;

  // status bit positions
  localparam int unsigned B_BUSERR = 0;
  localparam int unsigned B_START  = 1;
  localparam int unsigned B_END    = 2;
  localparam int unsigned B_STOP   = 3;
  localparam int unsigned B_RAS    = 4;
  localparam int unsigned B_REQPND = 8;
  localparam int unsigned B_EOR    = 9;
  localparam int unsigned B_CMP    = 10;

  // control bit positions
  localparam int unsigned B_MASKRUN = 22;
  localparam int unsigned B_RASEN   = 23;
  localparam int unsigned B_CLRCMP  = 24;
  localparam int unsigned B_SETCMP  = 25;
  localparam int unsigned B_EORIEN  = 28;
  localparam int unsigned B_STOPEN  = 29;
  localparam int unsigned B_RUN     = 31;

  localparam logic [WORD_W-1:0] KEEP_MASK  = 32'h0000_071F;
  localparam logic [WORD_W-1:0] W1C_MASK   = 32'h0000_0207;
  localparam logic [WORD_W-1:0] CTRL_MASK  = 32'hFC80_0000;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0008;
endpackage

// File: rtl/dma_csr_rstsync.sv
module dma_csr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ev_buserr,
  input  logic              ev_start,
  input  logic              ev_end,
  input  logic              ev_stop,
  input  logic              ev_ras,
  input  logic              ev_eor,
  output logic [WORD_W-1:0] st_q
);
  logic [WORD_W-1:0] st_d;
  logic              st_en;

  // next-state: write rules in order, then events on top
  always_comb begin
    st_d = st_q;
    if (wr_hit) begin
      st_d = (st_q & KEEP_MASK & ~(wr_data & W1C_MASK)) | (wr_data & CTRL_MASK);
      if (st_d[B_STOPEN])                          st_d[B_STOP] = 1'b0;
      if (wr_data[B_RUN])                          st_d[B_STOP] = 1'b0;
      if (!wr_data[B_RUN] && !wr_data[B_MASKRUN])  st_d[B_STOP] = 1'b1;
      if (wr_data[B_CLRCMP])                       st_d[B_CMP]  = 1'b0;
      if (wr_data[B_SETCMP])                       st_d[B_CMP]  = 1'b1;
    end
    if (ev_buserr) st_d[B_BUSERR] = 1'b1;
    if (ev_start)  st_d[B_START]  = 1'b1;
    if (ev_end)    st_d[B_END]    = 1'b1;
    if (ev_stop)   st_d[B_STOP]   = 1'b1;
    if (ev_ras)    st_d[B_RAS]    = 1'b1;
    if (ev_eor)    st_d[B_EOR]    = 1'b1;
  end

  assign st_en = wr_hit | ev_buserr | ev_start | ev_end | ev_stop | ev_ras | ev_eor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= RESET_WORD;
    else if (st_en) st_q <= st_d;
  end
endmodule

// File: rtl/dma_csr_sum.sv
module dma_csr_sum
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic [NCH-1:0][WORD_W-1:0] st,
  output logic [NCH-1:0]             sum_stop,
  output logic [NCH-1:0]             sum_eor,
  output logic [NCH-1:0]             sum_ras,
  output logic [NCH-1:0]             sum_start,
  output logic [NCH-1:0]             sum_end,
  output logic [NCH-1:0]             irq_vec,
  output logic                       irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_cause
    assign sum_stop[c]  = st[c][B_STOP] & st[c][B_STOPEN];
    assign sum_eor[c]   = st[c][B_EOR]  & st[c][B_EORIEN];
    assign sum_ras[c]   = st[c][B_RAS]  & st[c][B_RASEN];
    assign sum_start[c] = st[c][B_START];
    assign sum_end[c]   = st[c][B_END];
  end

  assign irq_vec = sum_stop | sum_eor | sum_ras | sum_start | sum_end;
  assign irq     = |irq_vec;
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 16,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_chan,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NCH-1:0]    ev_buserr,
  input  logic [NCH-1:0]    ev_start,
  input  logic [NCH-1:0]    ev_end,
  input  logic [NCH-1:0]    ev_stop,
  input  logic [NCH-1:0]    ev_ras,
  input  logic [NCH-1:0]    ev_eor,
  input  logic [NCH-1:0]    req_active,
  input  logic [CW-1:0]     rd_chan,
  output logic [WORD_W-1:0] rd_data,
  output logic [NCH-1:0]    sum_stop,
  output logic [NCH-1:0]    sum_eor,
  output logic [NCH-1:0]    sum_ras,
  output logic [NCH-1:0]    sum_start,
  output logic [NCH-1:0]    sum_end,
  output logic [NCH-1:0]    irq_vec,
  output logic              irq
);
  logic                       rst_sync_n;
  logic [NCH-1:0][WORD_W-1:0] st_q;

  dma_csr_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_csr_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_hit    (wr_en && (wr_chan == CW'(c))),
      .wr_data   (wr_data),
      .ev_buserr (ev_buserr[c]),
      .ev_start  (ev_start[c]),
      .ev_end    (ev_end[c]),
      .ev_stop   (ev_stop[c]),
      .ev_ras    (ev_ras[c]),
      .ev_eor    (ev_eor[c]),
      .st_q      (st_q[c])
    );
  end

  dma_csr_sum #(.NCH(NCH)) u_sum (
    .st        (st_q),
    .sum_stop  (sum_stop),
    .sum_eor   (sum_eor),
    .sum_ras   (sum_ras),
    .sum_start (sum_start),
    .sum_end   (sum_end),
    .irq_vec   (irq_vec),
    .irq       (irq)
  );

  always_comb begin
    rd_data = st_q[rd_chan];
    if (req_active[rd_chan]) rd_data[B_REQPND] = 1'b1;
  end
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk
  import dma_csr_pkg::*;
#(
  parameter int unsigned NCH = 16,
  localparam int unsigned CW = $clog2(NCH)
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       wr_en,
  input logic [CW-1:0]              wr_chan,
  input logic [WORD_W-1:0]          wr_data,
  input logic [NCH-1:0]             ev_start,
  input logic [NCH-1:0]             ev_stop,
  input logic [NCH-1:0]             req_active,
  input logic [CW-1:0]              rd_chan,
  input logic [WORD_W-1:0]          rd_data,
  input logic [NCH-1:0][WORD_W-1:0] st_q,
  input logic [NCH-1:0]             sum_stop,
  input logic [NCH-1:0]             sum_start,
  input logic [NCH-1:0]             irq_vec,
  input logic                       irq
);
  logic [NCH-1:0] stop_en;
  always_comb
    for (int c = 0; c < NCH; c++) stop_en[c] = st_q[c][B_STOPEN];

  assert_run_clears_stop_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_data[B_RUN] && !ev_stop[wr_chan]) |=> !st_q[$past(wr_chan)][B_STOP]);

  assert_set_compare_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_data[B_SETCMP]) |=> st_q[$past(wr_chan)][B_CMP]);

  assert_start_event_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_start != '0) |=> ((sum_start & $past(ev_start)) == $past(ev_start)));

  assert_stop_event_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_stop[0] |=> st_q[0][B_STOP]);

  assert_stop_gated_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sum_stop & ~stop_en) == '0);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq == (irq_vec != '0));

  assert_req_pending_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_active[rd_chan] |-> rd_data[B_REQPND]);
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_chan    (wr_chan),
  .wr_data    (wr_data),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .req_active (req_active),
  .rd_chan    (rd_chan),
  .rd_data    (rd_data),
  .st_q       (st_q),
  .sum_stop   (sum_stop),
  .sum_start  (sum_start),
  .irq_vec    (irq_vec),
  .irq        (irq)
);

// File: tb/dma_chan_csr_test.sv
module dma_chan_csr_test;
  localparam int unsigned NCH = 16;
  localparam int unsigned CW  = $clog2(NCH);
  localparam time CLK_PERIOD  = 10ns;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [CW-1:0]   wr_chan;
  logic [31:0]     wr_data;
  logic [NCH-1:0]  ev_buserr, ev_start, ev_end, ev_stop, ev_ras, ev_eor, req_active;
  logic [CW-1:0]   rd_chan;
  logic [31:0]     rd_data;
  logic [NCH-1:0]  sum_stop, sum_eor, sum_ras, sum_start, sum_end, irq_vec;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_csr #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
    .ev_buserr(ev_buserr), .ev_start(ev_start), .ev_end(ev_end), .ev_stop(ev_stop),
    .ev_ras(ev_ras), .ev_eor(ev_eor), .req_active(req_active), .rd_chan(rd_chan),
    .rd_data(rd_data), .sum_stop(sum_stop), .sum_eor(sum_eor), .sum_ras(sum_ras),
    .sum_start(sum_start), .sum_end(sum_end), .irq_vec(irq_vec), .irq(irq)
  );

  // {write data, expected word, expected irq}, applied in order to channel 2
  localparam logic [64:0] VEC [0:6] = '{
    {32'h8000_0000, 32'h8000_0000, 1'b0},  // R4 run clears stop
    {32'h0040_0000, 32'h0000_0000, 1'b0},  // R2 control rewritten, mask-run holds stop off
    {32'h0000_0000, 32'h0000_0008, 1'b0},  // R4 no run, no mask-run sets stop
    {32'h2000_0000, 32'h2000_0008, 1'b1},  // R4 order: enable clears, then set; R7
    {32'h8300_0000, 32'h8000_0400, 1'b0},  // R5 set wins over clear
    {32'h8100_0000, 32'h8000_0000, 1'b0},  // R5 clear compare
    {32'h9080_0000, 32'h9080_0000, 1'b0}   // R2 enables stored
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic clear_inputs();
    wr_en = 0; wr_data = '0; wr_chan = '0;
    ev_buserr = '0; ev_start = '0; ev_end = '0; ev_stop = '0; ev_ras = '0; ev_eor = '0;
  endtask

  // inputs were set just after a falling edge; move to the next falling edge
  task automatic step();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic wr(input int ch, input logic [31:0] d);
    wr_en = 1; wr_chan = CW'(ch); wr_data = d;
  endtask

  task automatic rd(input int ch);
    rd_chan = CW'(ch);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    clear_inputs();
    req_active = '0;
    rd_chan = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      rd(c);
      check("R1 reset word", rd_data, 32'h8);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    check("R1 reset irq_vec", 32'(irq_vec), 32'd0);

    // table walk on channel 2
    for (int i = 0; i < 7; i++) begin
      wr(2, VEC[i][64:33]);
      step();
      rd(2);
      check($sformatf("R2/R4/R5 vector %0d word", i), rd_data, VEC[i][32:1]);
      check($sformatf("R7 vector %0d irq", i), {31'd0, irq}, {31'd0, VEC[i][0]});
    end

    // R11 then R6/R7: end-of-receive event
    ev_eor[2] = 1;
    #1;
    check("R11 irq before edge", {31'd0, irq}, 32'd0);
    step();
    rd(2);
    check("R6 eor sets bit 9", rd_data, 32'h9080_0200);
    check("R7 eor cause", 32'(sum_eor), 32'h0004);
    check("R9 irq from eor", {31'd0, irq}, 32'd1);

    // R6 event beats a clearing write in the same cycle
    wr(2, 32'h9080_0200); ev_eor[2] = 1;
    step();
    rd(2);
    check("R6 event priority", rd_data, 32'h9080_0200);

    // R3 clearing write alone
    wr(2, 32'h9080_0200);
    step();
    rd(2);
    check("R3 w1c eor", rd_data, 32'h9080_0000);
    check("R3 irq low", {31'd0, irq}, 32'd0);

    // R7 request-asserted gated by bit 23; R3 bit 4 not write-clearable
    ev_ras[2] = 1;
    step();
    check("R7 ras cause", 32'(sum_ras), 32'h0004);
    wr(2, 32'h0000_0010);
    step();
    rd(2);
    check("R3 ras kept", rd_data, 32'h0000_0018);
    check("R7 ras gated off", 32'(sum_ras), 32'd0);
    check("R7 irq off", {31'd0, irq}, 32'd0);

    // R8 start ungated
    ev_start[5] = 1;
    step();
    rd(5);
    check("R8 start word", rd_data, 32'h0000_000A);
    check("R8 start cause", 32'(sum_start), 32'h0020);
    check("R9 irq_vec start", 32'(irq_vec), 32'h0020);
    wr(5, 32'h0000_0002);
    step();
    rd(5);
    check("R3 w1c start", rd_data, 32'h8);
    check("R8 start cleared irq", {31'd0, irq}, 32'd0);

    // R8 end ungated on top channel
    ev_end[NCH-1] = 1;
    step();
    check("R8 end cause", 32'(sum_end), 32'h8000);
    wr(NCH-1, 32'h0000_0004);
    step();
    rd(NCH-1);
    check("R3 w1c end", rd_data, 32'h8);

    // R8 bus error raises no cause
    ev_buserr[0] = 1;
    step();
    rd(0);
    check("R6 buserr bit", rd_data, 32'h9);
    check("R8 buserr no irq", {31'd0, irq}, 32'd0);
    wr(0, 32'h0000_0001);
    step();
    rd(0);
    check("R3 w1c buserr", rd_data, 32'h8);

    // R10 request pending readback only
    req_active[3] = 1;
    rd(3);
    check("R10 pending shown", rd_data, 32'h108);
    req_active[3] = 0;
    rd(3);
    check("R10 not stored", rd_data, 32'h8);

    // R4/R7 stop with its enable
    wr(6, 32'hA000_0000);
    step();
    rd(6);
    check("R4 run+enable word", rd_data, 32'hA000_0000);
    ev_stop[6] = 1;
    step();
    rd(6);
    check("R6 stop event", rd_data, 32'hA000_0008);
    check("R7 stop cause", 32'(irq_vec), 32'h0040);
    wr(6, 32'hA000_0000);
    step();
    rd(6);
    check("R4 enable clears stop", rd_data, 32'hA000_0000);
    check("R4 irq low", {31'd0, irq}, 32'd0);

    // R6 stop event beats run write
    wr(7, 32'h8000_0000); ev_stop[7] = 1;
    step();
    rd(7);
    check("R6 stop beats run", rd_data, 32'h8000_0008);

    // R2 unstored bits and mask-run
    wr(8, 32'h0340_F8E0);
    step();
    rd(8);
    check("R2 unstored bits", rd_data, 32'h0000_0408);

    finish_run();
  end
endmodule